// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block holds the program counter of a single-cycle processor and produces the byte address of the instruction to fetch. Instructions are 32 bits wide and always aligned, so the counter is stored as a 30-bit word index. The byte address is that index with two zero bits appended. Every instruction passes through the same fetch step. On each rising clock edge the counter loads exactly one of three values: the sequential successor, a taken-branch target, or a jump target.

The decoder supplies a branch-select control and a jump control. The register-compare logic supplies an equal flag. The instruction word supplies a 16-bit signed word offset and a 26-bit word target. Outputs are the current fetch address and the address of the next sequential instruction (fetch address plus 4), which later stages use as the return or link value. All ports are plain control and data pins: there is no stream traffic at this edge, so there is no valid/ready handshake and no back-pressure. The instruction memory, the compare and the decode all live outside this block.

Top module: `ifetch_npc`

## Requirements
- R1: A synchronous, active-high `rst` sampled at a rising edge sets the word counter to 0. After that edge `fetch_addr` reads 0 and `seq_addr` reads 4.
- R2: `fetch_addr[1:0]` is always 0, and `fetch_addr[31:2]` is the stored 30-bit word counter.
- R3: The sequential case applies when `jmp` is 0 and either `br_sel` or `eq_flag` is 0. After the edge, `fetch_addr` equals the previous `fetch_addr` plus 4.
- R4: In every cycle, `seq_addr` equals `fetch_addr + 4` modulo 2^32, combinationally from the stored counter.
- R5: A branch is taken when `br_sel`=1, `eq_flag`=1 and `jmp`=0. After the edge, the word counter is old counter + 1 + `imm_off` sign-extended from bit 15 to 30 bits, with no shift. In bytes, this is the previous `seq_addr` plus the offset times 4.
- R6: `br_sel`=1 with `eq_flag`=0 gives the sequential value, and so does `eq_flag`=1 with `br_sel`=0.
- R7: When `jmp`=1, the word counter after the edge is {bits 29:26 of (old counter + 1), `jmp_tgt`[25:0]}.
- R8: `jmp` takes priority over a taken branch. With all three controls at 1, the jump target is loaded.
- R9: All counter arithmetic wraps modulo 2^30, with no overflow indication. Counter 0x3FFFFFFF steps to 0, and a negative offset from a low counter wraps to the top of the range.
- R10: `imm_off` has no effect unless a branch is taken, and `jmp_tgt` has no effect unless `jmp` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_sel | input | 1 | Current instruction is a conditional branch |
| eq_flag | input | 1 | Branch condition met (operands equal) |
| jmp | input | 1 | Current instruction is an absolute jump |
| imm_off | input | 16 | Signed branch offset in words |
| jmp_tgt | input | 26 | Jump target word index, low 26 bits |
| fetch_addr | output | 32 | Byte address of the instruction being fetched |
| seq_addr | output | 32 | Byte address of the next sequential instruction |

## Verification
The bench sweeps all 65536 branch offsets with the branch taken, starting from an evolving counter. A design that shifted the offset, zero-extended it, or dropped the +1 would land on the wrong word for many of them. It drives all eight combinations of the three controls. This exposes a branch taken on only one of its two qualifiers, and a branch that wins over a jump. A negative offset from counter 0 steers the counter to 0x3FFFFFFF. From there the bench checks two things: a sequential step, which a design that saturates or carries into the byte bits gets wrong, and a jump, whose upper four bits must come from the wrapped successor (0) rather than from the old counter (0xF). Sequential steps with random offset and target values show whether unused fields leak into the result.

// File: rtl/npc_pkg.sv
package npc_pkg;
  // Number of always-zero low bits in an aligned 32-bit instruction address.
  localparam int ALIGN_W = 2;

  // Which candidate the counter loads at the next edge.
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } npc_src_e;
endpackage

// File: rtl/npc_src_sel.sv
module npc_src_sel
  import npc_pkg::*;
(
  input  logic     br_sel,
  input  logic     eq_flag,
  input  logic     jmp,
  output npc_src_e src
);
  // Jump outranks a taken branch (R8); a branch needs both qualifiers (R6).
  always_comb begin
    if (jmp)                    src = SRC_JUMP;
    else if (br_sel && eq_flag) src = SRC_BRANCH;
    else                        src = SRC_SEQ;
  end
endmodule

// File: rtl/npc_calc.sv
module npc_calc
  import npc_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic [WORD_W-1:0] pc_q,
  input  npc_src_e          src,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [TGT_W-1:0]  jmp_tgt,
  output logic [WORD_W-1:0] seq_word,
  output logic [WORD_W-1:0] pc_d
);
  localparam int EXT_W = WORD_W - IMM_W;
  localparam int HI_W  = WORD_W - TGT_W;

  logic [WORD_W-1:0] off_word;
  logic [WORD_W-1:0] br_word;
  logic [WORD_W-1:0] jmp_word;

  // Successor word; wraps modulo 2^WORD_W (R9).
  assign seq_word = pc_q + WORD_W'(1);

  // Sign extension of the word offset, no shift (R5).
  generate
    if (EXT_W > 0) begin : g_ext
      assign off_word = {{EXT_W{imm_off[IMM_W-1]}}, imm_off};
    end else begin : g_trunc
      assign off_word = imm_off[WORD_W-1:0];
    end
  endgenerate

  assign br_word = seq_word + off_word;

  // Jump keeps the upper bits of the successor region (R7).
  generate
    if (HI_W > 0) begin : g_region
      assign jmp_word = {seq_word[WORD_W-1 -: HI_W], jmp_tgt};
    end else begin : g_full
      assign jmp_word = jmp_tgt[WORD_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_JUMP:   pc_d = jmp_word;
      SRC_BRANCH: pc_d = br_word;
      default:    pc_d = seq_word;
    endcase
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] pc_d,
  output logic [WORD_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  // R1: a reset edge leaves the counter at zero.
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (pc_q == '0))
    else $error("p_reset_clear_r1");
endmodule

// File: rtl/ifetch_npc.sv
module ifetch_npc
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_sel,
  input  logic              eq_flag,
  input  logic              jmp,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [TGT_W-1:0]  jmp_tgt,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] seq_addr
);
  localparam int WORD_W = ADDR_W - ALIGN_W;
  localparam int BEXT_W = ADDR_W - IMM_W - ALIGN_W;

  npc_src_e          src;
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] pc_d;
  logic [WORD_W-1:0] seq_word;

  npc_src_sel u_sel (
    .br_sel (br_sel),
    .eq_flag(eq_flag),
    .jmp    (jmp),
    .src    (src)
  );

  npc_calc #(.WORD_W(WORD_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_calc (
    .pc_q    (pc_q),
    .src     (src),
    .imm_off (imm_off),
    .jmp_tgt (jmp_tgt),
    .seq_word(seq_word),
    .pc_d    (pc_d)
  );

  npc_pc_reg #(.WORD_W(WORD_W)) u_pc (
    .clk (clk),
    .rst (rst),
    .pc_d(pc_d),
    .pc_q(pc_q)
  );

  // Byte addresses: word index followed by the zero alignment bits (R2, R4).
  assign fetch_addr = {pc_q, {ALIGN_W{1'b0}}};
  assign seq_addr   = {seq_word, {ALIGN_W{1'b0}}};

  // R3/R6: without a jump or a qualified branch, the next fetch is last cycle's successor.
  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !(br_sel && eq_flag)) |=> (fetch_addr == $past(seq_addr)))
    else $error("p_seq_step_r3");

  // R5: a taken branch moves by the offset in words from the successor.
  p_branch_target_r5: assert property (@(posedge clk) disable iff (rst)
    (br_sel && eq_flag && !jmp) |=>
      (fetch_addr == $past(seq_addr) +
        {{BEXT_W{$past(imm_off[IMM_W-1])}}, $past(imm_off), {ALIGN_W{1'b0}}}))
    else $error("p_branch_target_r5");

  // R7/R8: a jump loads the target field, even when a branch is also taken.
  p_jump_field_r7: assert property (@(posedge clk) disable iff (rst)
    jmp |=> (fetch_addr[TGT_W+ALIGN_W-1:ALIGN_W] == $past(jmp_tgt)))
    else $error("p_jump_field_r7");

  // R7/R9: a jump keeps the region bits of the wrapped successor.
  p_jump_region_r7: assert property (@(posedge clk) disable iff (rst)
    jmp |=> (fetch_addr[ADDR_W-1:TGT_W+ALIGN_W] ==
             $past(seq_addr[ADDR_W-1:TGT_W+ALIGN_W])))
    else $error("p_jump_region_r7");
endmodule

// File: tb/ifetch_npc_tb.sv
module ifetch_npc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_sel = 1'b0;
  logic        eq_flag = 1'b0;
  logic        jmp = 1'b0;
  logic [15:0] imm_off = '0;
  logic [25:0] jmp_tgt = '0;
  logic [31:0] fetch_addr;
  logic [31:0] seq_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [29:0] model = '0;

  always #10 clk = ~clk;  // 50 MHz

  ifetch_npc u_dut (
    .clk(clk), .rst(rst), .br_sel(br_sel), .eq_flag(eq_flag), .jmp(jmp),
    .imm_off(imm_off), .jmp_tgt(jmp_tgt), .fetch_addr(fetch_addr), .seq_addr(seq_addr)
  );

  task automatic check32(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; applies one cycle of controls and checks both outputs.
  task automatic step(input logic b, input logic e, input logic j,
                      input logic [15:0] im, input logic [25:0] tg, input string tag);
    logic [29:0] nxt;
    logic [29:0] succ;
    br_sel = b; eq_flag = e; jmp = j; imm_off = im; jmp_tgt = tg;
    #2;
    check32(seq_addr, {model + 30'd1, 2'b00}, "R4 seq_addr");
    succ = model + 30'd1;
    if (j)           nxt = {succ[29:26], tg};
    else if (b && e) nxt = succ + {{14{im[15]}}, im};
    else             nxt = succ;
    @(negedge clk);
    model = nxt;
    check32(fetch_addr, {model, 2'b00}, tag);
    check32({30'd0, fetch_addr[1:0]}, 32'd0, "R2 alignment");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    check32(fetch_addr, 32'd0, "R1 reset fetch_addr");
    check32(seq_addr, 32'd4, "R1 reset seq_addr");

    // R3 and R10: sequential flow with unused fields toggling.
    for (int i = 0; i < 64; i++)
      step(1'b0, 1'b0, 1'b0, 16'($urandom), 26'($urandom), "R3 R10 sequential");

    // R6: a single branch qualifier alone does not redirect.
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, 1'b0, 16'h0100, 26'h0, "R6 br_sel without eq");
      step(1'b0, 1'b1, 1'b0, 16'h0100, 26'h0, "R6 eq without br_sel");
    end

    // R8: all eight control combinations, with a distinctive offset and target.
    for (int c = 0; c < 8; c++)
      step(c[2], c[1], c[0], 16'h8003, 26'h2AAAAAA, "R8 control combination");

    // R5: every branch offset, taken.
    for (int i = 0; i < 65536; i++)
      step(1'b1, 1'b1, 1'b0, 16'(i), 26'($urandom), "R5 taken branch sweep");

    // R7: jump targets across the field, walking single bits and random values.
    for (int i = 0; i < 26; i++)
      step(1'b0, 1'b0, 1'b1, 16'($urandom), 26'(1) << i, "R7 jump walking bit");
    for (int i = 0; i < 256; i++)
      step(1'b1, 1'($urandom), 1'b1, 16'($urandom), 26'($urandom), "R7 jump random");

    // R9: wrap from the bottom and the top of the word range.
    rst = 1'b1; @(negedge clk); rst = 1'b0; model = '0;
    check32(fetch_addr, 32'd0, "R1 second reset");
    step(1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0, "R9 negative offset wraps to top");
    check32(fetch_addr, 32'hFFFF_FFFC, "R9 top of range");
    check32(seq_addr, 32'd0, "R9 successor wraps");
    step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0, "R9 sequential wrap");
    check32(fetch_addr, 32'd0, "R9 wrapped to zero");
    step(1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0, "R9 back to top");
    step(1'b0, 1'b0, 1'b1, 16'h0, 26'h0000123, "R9 R7 jump region from wrap");
    check32(fetch_addr, {4'h0, 26'h0000123, 2'b00}, "R9 R7 region uses wrapped successor");
    step(1'b1, 1'b1, 1'b0, 16'h7FFF, 26'h0, "R5 max positive offset");
    step(1'b1, 1'b1, 1'b0, 16'h8000, 26'h0, "R5 max negative offset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule